// File: doc/BRIEF.md
# Write-Cycle Status Read Responder

This block sits on the read path of a byte-wide nonvolatile memory. It decides what the host sees on the data bus while an internal write cycle is running. A write timer drives `busy_i`. When `busy_i` rises, the block captures the address and the byte that were written last. It then hides the array contents behind two completion indicators, and both run at the same time.

The first indicator is an inverted top bit. It appears on reads of the byte that was just written. The second is a status bit that flips each time the host completes a read strobe. Once the timer drops `busy_i`, reads return the array byte unchanged. A write-accept flag then tells the write logic that a new cycle may begin.

The read enable is a level that the host holds for one or more clocks. `rd_data_o` is registered, so a read's data appears on the clock after the enable is sampled. Bit positions default to 7 for the polling bit and 6 for the toggle bit. Both are parameters.

Top module: `wcs_read_responder`

## Requirements
- R1: While `busy_i` is high, a read whose address equals the captured write address returns the complement of the captured byte's bit 7 on data bit 7.
- R2: While `busy_i` is high, data bit 6 of every read, at any address, equals an internal toggle state. The toggle state inverts once for each completed read strobe, that is, once at each high-to-low transition of `rd_en_i` that occurs while `busy_i` is high. It does not change per clock.
- R3: While `busy_i` is high, bits 5..0 of a read come from a source that depends on the address. At the captured address they come from the captured byte. At any other address they come from `arr_data_i`, and in that case bit 7 also comes from `arr_data_i`.
- R4: While `busy_i` is low, a read returns `arr_data_i` unchanged on all bits, and repeated reads show no alternation on bit 6.
- R5: `wr_accept_o` is low in the clock after any cycle with `busy_i` high. It is high in the clock after any cycle with `busy_i` low, which is the same clock in which true data is first returned.
- R6: The cycle in which `busy_i` rises counts as the start of a write. In that cycle the toggle state is cleared to 0, even if a strobe ends in that same cycle. A read sampled in the start cycle already shows status, built from the `wr_addr_i` and `wr_data_i` values present in that cycle.
- R7: `rd_data_o` updates one clock after `rd_en_i` is sampled. It is all zeros in the clock after a cycle with `rd_en_i` low.
- R8: The write address and byte are captured only in the start cycle. Changes on `wr_addr_i` or `wr_data_i` during the rest of a busy period have no effect on read results.
- R9: Synchronous reset drives `rd_data_o` to zero, `wr_accept_o` to one and the toggle state to zero. A `busy_i` that is high at the first clock after reset counts as a new write start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_i | input | 1 | High while the internal write timer runs |
| wr_addr_i | input | AW | Address of the last byte written |
| wr_data_i | input | DW | Value of the last byte written |
| rd_en_i | input | 1 | Combined read enable level; one strobe per high period |
| rd_addr_i | input | AW | Read address |
| arr_data_i | input | DW | Array contents at `rd_addr_i` |
| rd_data_o | output | DW | Registered data bus value |
| wr_accept_o | output | 1 | Registered; high when a new write cycle may start |

## Verification
Several events that the host sees as separate can fall in a single clock, and these cases are the hardest to reach. One is a strobe that ends in the same cycle in which `busy_i` rises. Another is a read that is sampled in the start cycle itself, before any capture register holds the new byte. A third is a read strobe that is still open when `busy_i` falls. The stimulus table builds each of these on purpose by lining up the edges of `rd_enable` and `busy_i` in adjacent rows. It also leaves the toggle state at 1 across an idle stretch, so that a clear at the next start can be observed. Captured-field isolation is tested separately: new values are driven on the write inputs in the middle of a busy period, and a later read shows they were ignored.

// File: rtl/wcs_pkg.sv
package wcs_pkg;

  // Classification of the current read access
  typedef enum logic [1:0] {
    RD_NONE       = 2'd0,  // no read in this cycle
    RD_TRUE       = 2'd1,  // idle read, array data passes through
    RD_POLL_MATCH = 2'd2,  // busy read of the captured address
    RD_POLL_OTHER = 2'd3   // busy read of any other address
  } rd_kind_e;

endpackage

// File: rtl/wcs_write_tracker.sv
module wcs_write_tracker #(
  parameter int AW = 13,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          busy_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          start_o,
  output logic [AW-1:0] snap_addr_o,
  output logic [DW-1:0] snap_data_o,
  output logic          accept_o
);

  logic          busy_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  assign start_o = busy_i & ~busy_q;

  // In the start cycle the registers are not yet loaded: forward the inputs
  assign snap_addr_o = start_o ? wr_addr_i : addr_q;
  assign snap_data_o = start_o ? wr_data_i : data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q   <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      accept_o <= 1'b1;
    end else begin
      busy_q   <= busy_i;
      accept_o <= ~busy_i;
      if (start_o) begin
        addr_q <= wr_addr_i;
        data_q <= wr_data_i;
      end
    end
  end

  AST_ACCEPT_LOW_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> !accept_o);  // R5

  AST_SNAPSHOT_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy_i && busy_q) |=> ($stable(addr_q) && $stable(data_q)));  // R8

endmodule

// File: rtl/wcs_toggle_gen.sv
module wcs_toggle_gen (
  input  logic clk,
  input  logic rst,
  input  logic busy_i,
  input  logic start_i,
  input  logic rd_en_i,
  output logic tog_o
);

  logic rd_q;
  logic tog_q;
  logic strobe_end;

  assign strobe_end = rd_q & ~rd_en_i;
  assign tog_o      = start_i ? 1'b0 : tog_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q  <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      rd_q <= rd_en_i;
      if (start_i)
        tog_q <= 1'b0;
      else if (busy_i && strobe_end)
        tog_q <= ~tog_q;
    end
  end

  AST_TOGGLE_FLIPS_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    (busy_i && strobe_end && !start_i) |=> (tog_q != $past(tog_q)));  // R2

  AST_TOGGLE_STEADY_OTHERWISE: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !(busy_i && strobe_end)) |=> $stable(tog_q));  // R2

  AST_TOGGLE_CLEARED_AT_START: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (tog_q == 1'b0));  // R6

endmodule

// File: rtl/wcs_read_classifier.sv
module wcs_read_classifier #(
  parameter int AW = 13
) (
  input  logic              rd_en_i,
  input  logic              busy_i,
  input  logic [AW-1:0]     rd_addr_i,
  input  logic [AW-1:0]     snap_addr_i,
  output wcs_pkg::rd_kind_e kind_o
);

  logic hit;

  assign hit = (rd_addr_i == snap_addr_i);

  always_comb begin
    if (!rd_en_i)
      kind_o = wcs_pkg::RD_NONE;
    else if (!busy_i)
      kind_o = wcs_pkg::RD_TRUE;
    else if (hit)
      kind_o = wcs_pkg::RD_POLL_MATCH;
    else
      kind_o = wcs_pkg::RD_POLL_OTHER;
  end

endmodule

// File: rtl/wcs_status_mux.sv
module wcs_status_mux #(
  parameter int DW       = 8,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  wcs_pkg::rd_kind_e kind_i,
  input  logic [DW-1:0]     arr_data_i,
  input  logic [DW-1:0]     snap_data_i,
  input  logic              tog_i,
  output logic [DW-1:0]     rd_data_o
);

  logic [DW-1:0] next_data;

  for (genvar b = 0; b < DW; b++) begin : g_bit
    if (b == POLL_BIT) begin : g_poll
      always_comb begin
        unique case (kind_i)
          wcs_pkg::RD_TRUE:       next_data[b] = arr_data_i[b];
          wcs_pkg::RD_POLL_MATCH: next_data[b] = ~snap_data_i[b];
          wcs_pkg::RD_POLL_OTHER: next_data[b] = arr_data_i[b];
          default:                next_data[b] = 1'b0;
        endcase
      end
    end else if (b == TOG_BIT) begin : g_tog
      always_comb begin
        unique case (kind_i)
          wcs_pkg::RD_TRUE:       next_data[b] = arr_data_i[b];
          wcs_pkg::RD_POLL_MATCH: next_data[b] = tog_i;
          wcs_pkg::RD_POLL_OTHER: next_data[b] = tog_i;
          default:                next_data[b] = 1'b0;
        endcase
      end
    end else begin : g_plain
      always_comb begin
        unique case (kind_i)
          wcs_pkg::RD_TRUE:       next_data[b] = arr_data_i[b];
          wcs_pkg::RD_POLL_MATCH: next_data[b] = snap_data_i[b];
          wcs_pkg::RD_POLL_OTHER: next_data[b] = arr_data_i[b];
          default:                next_data[b] = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else     rd_data_o <= next_data;
  end

  AST_BUS_QUIET_WITHOUT_READ: assert property (@(posedge clk) disable iff (rst)
    (kind_i == wcs_pkg::RD_NONE) |=> (rd_data_o == '0));  // R7

  AST_POLL_BIT_INVERTED: assert property (@(posedge clk) disable iff (rst)
    (kind_i == wcs_pkg::RD_POLL_MATCH) |=>
      (rd_data_o[POLL_BIT] != $past(snap_data_i[POLL_BIT])));  // R1

  AST_TOG_BIT_SHOWN: assert property (@(posedge clk) disable iff (rst)
    (kind_i == wcs_pkg::RD_POLL_OTHER) |=> (rd_data_o[TOG_BIT] == $past(tog_i)));  // R2

endmodule

// File: rtl/wcs_read_responder.sv
module wcs_read_responder #(
  parameter int AW       = 13,
  parameter int DW       = 8,
  parameter int POLL_BIT = 7,
  parameter int TOG_BIT  = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          busy_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic [DW-1:0] arr_data_i,
  output logic [DW-1:0] rd_data_o,
  output logic          wr_accept_o
);

  logic              start;
  logic [AW-1:0]     snap_addr;
  logic [DW-1:0]     snap_data;
  logic              tog;
  wcs_pkg::rd_kind_e kind;

  wcs_write_tracker #(.AW(AW), .DW(DW)) i_tracker (
    .clk        (clk),
    .rst        (rst),
    .busy_i     (busy_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .start_o    (start),
    .snap_addr_o(snap_addr),
    .snap_data_o(snap_data),
    .accept_o   (wr_accept_o)
  );

  wcs_toggle_gen i_toggle (
    .clk    (clk),
    .rst    (rst),
    .busy_i (busy_i),
    .start_i(start),
    .rd_en_i(rd_en_i),
    .tog_o  (tog)
  );

  wcs_read_classifier #(.AW(AW)) i_classify (
    .rd_en_i    (rd_en_i),
    .busy_i     (busy_i),
    .rd_addr_i  (rd_addr_i),
    .snap_addr_i(snap_addr),
    .kind_o     (kind)
  );

  wcs_status_mux #(.DW(DW), .POLL_BIT(POLL_BIT), .TOG_BIT(TOG_BIT)) i_mux (
    .clk        (clk),
    .rst        (rst),
    .kind_i     (kind),
    .arr_data_i (arr_data_i),
    .snap_data_i(snap_data),
    .tog_i      (tog),
    .rd_data_o  (rd_data_o)
  );

  AST_IDLE_READ_TRUE_DATA: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !busy_i) |=> (rd_data_o == $past(arr_data_i)));  // R4

  AST_ACCEPT_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    !busy_i |=> wr_accept_o);  // R5

endmodule

// File: tb/test_wcs_read_responder.sv
module test_wcs_read_responder;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 13;
  localparam int DW = 8;
  localparam int NV = 24;

  // Row: busy, rd, wr_addr, wr_data, rd_addr, arr, expected data, expected accept
  localparam logic [52:0] VEC [NV] = '{
    {1'b0, 1'b1, 13'h000, 8'h00, 13'h010, 8'h5A, 8'h5A, 1'b1},  // 0
    {1'b0, 1'b0, 13'h000, 8'h00, 13'h000, 8'h00, 8'h00, 1'b1},  // 1
    {1'b1, 1'b1, 13'h123, 8'hC5, 13'h123, 8'h00, 8'h05, 1'b0},  // 2
    {1'b1, 1'b0, 13'h050, 8'h3A, 13'h000, 8'h00, 8'h00, 1'b0},  // 3
    {1'b1, 1'b1, 13'h000, 8'h00, 13'h123, 8'h00, 8'h45, 1'b0},  // 4
    {1'b1, 1'b1, 13'h000, 8'h00, 13'h123, 8'h00, 8'h45, 1'b0},  // 5
    {1'b1, 1'b0, 13'h000, 8'h00, 13'h000, 8'h00, 8'h00, 1'b0},  // 6
    {1'b1, 1'b1, 13'h000, 8'h00, 13'h050, 8'hD3, 8'h93, 1'b0},  // 7
    {1'b1, 1'b0, 13'h000, 8'h00, 13'h000, 8'h00, 8'h00, 1'b0},  // 8
    {1'b1, 1'b1, 13'h000, 8'h00, 13'h050, 8'h13, 8'h53, 1'b0},  // 9
    {1'b0, 1'b0, 13'h000, 8'h00, 13'h000, 8'h00, 8'h00, 1'b1},  // 10
    {1'b0, 1'b1, 13'h000, 8'h00, 13'h123, 8'hC5, 8'hC5, 1'b1},  // 11
    {1'b0, 1'b0, 13'h000, 8'h00, 13'h000, 8'h00, 8'h00, 1'b1},  // 12
    {1'b0, 1'b1, 13'h000, 8'h00, 13'h123, 8'hC5, 8'hC5, 1'b1},  // 13
    {1'b0, 1'b0, 13'h000, 8'h00, 13'h000, 8'h00, 8'h00, 1'b1},  // 14
    {1'b1, 1'b1, 13'h200, 8'h3C, 13'h200, 8'h00, 8'hBC, 1'b0},  // 15
    {1'b1, 1'b0, 13'h000, 8'h00, 13'h000, 8'h00, 8'h00, 1'b0},  // 16
    {1'b1, 1'b1, 13'h000, 8'h00, 13'h200, 8'h00, 8'hFC, 1'b0},  // 17
    {1'b0, 1'b1, 13'h000, 8'h00, 13'h200, 8'h3C, 8'h3C, 1'b1},  // 18
    {1'b0, 1'b0, 13'h000, 8'h00, 13'h000, 8'h00, 8'h00, 1'b1},  // 19
    {1'b0, 1'b1, 13'h000, 8'h00, 13'h001, 8'h11, 8'h11, 1'b1},  // 20
    {1'b1, 1'b0, 13'h001, 8'h00, 13'h000, 8'h00, 8'h00, 1'b0},  // 21
    {1'b1, 1'b1, 13'h000, 8'h00, 13'h001, 8'hFF, 8'h80, 1'b0},  // 22
    {1'b0, 1'b0, 13'h000, 8'h00, 13'h000, 8'h00, 8'h00, 1'b1}   // 23
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          busy = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] arr_data = '0;
  logic [DW-1:0] rd_data;
  logic          wr_accept;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  wcs_read_responder #(.AW(AW), .DW(DW)) i_wcs_read_responder (
    .clk        (clk),
    .rst        (rst),
    .busy_i     (busy),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .rd_en_i    (rd_en),
    .rd_addr_i  (rd_addr),
    .arr_data_i (arr_data),
    .rd_data_o  (rd_data),
    .wr_accept_o(wr_accept)
  );

  function automatic string row_req(int i);
    case (i)
      0, 13, 20:                 return "R4";
      2:                         return "R1,R6";
      4:                         return "R2,R8";
      5:                         return "R2";
      7, 9:                      return "R3";
      10, 11, 18, 23:            return "R5";
      15, 21, 22:                return "R6";
      17:                        return "R1";
      default:                   return "R7";
    endcase
  endfunction

  task automatic check_data(string req, logic [DW-1:0] exp);
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s rd_data actual=%02h expected=%02h", req, rd_data, exp);
    end
  endtask

  task automatic check_acc(string req, logic exp);
    checks++;
    if (wr_accept !== exp) begin
      errors++;
      $display("FAIL %s wr_accept actual=%0b expected=%0b", req, wr_accept, exp);
    end
  endtask

  task automatic drive(logic b, logic r, logic [AW-1:0] wa, logic [DW-1:0] wd,
                       logic [AW-1:0] ra, logic [DW-1:0] ad);
    busy = b; rd_en = r; wr_addr = wa; wr_data = wd; rd_addr = ra; arr_data = ad;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check_data("R9", 8'h00);  // R9 reset state
    check_acc("R9", 1'b1);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][52], VEC[i][51], VEC[i][50:38], VEC[i][37:30],
            VEC[i][29:17], VEC[i][16:9]);
      @(posedge clk);
      #1;
      check_data(row_req(i), VEC[i][8:1]);
      check_acc(row_req(i), VEC[i][0]);
    end

    // R9: reset in the middle of a busy read
    @(negedge clk);
    drive(1'b1, 1'b1, 13'h200, 8'h80, 13'h200, 8'h00);
    @(posedge clk); #1;
    check_data("R6", 8'h00);  // start with captured bit 7 = 1 -> poll bit 0
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); #1;
    check_data("R9", 8'h00);
    check_acc("R9", 1'b1);
    @(negedge clk);
    rst = 1'b0;
    drive(1'b0, 1'b1, 13'h000, 8'h00, 13'h200, 8'h77);
    @(posedge clk); #1;
    check_data("R9", 8'h77);
    check_acc("R9", 1'b1);
    // R9: busy after reset is a fresh start, toggle begins at 0
    @(negedge clk);
    drive(1'b1, 1'b1, 13'h010, 8'h00, 13'h010, 8'hFF);
    @(posedge clk); #1;
    check_data("R9", 8'h80);
    check_acc("R9", 1'b0);
    @(negedge clk);
    drive(1'b0, 1'b0, 13'h000, 8'h00, 13'h000, 8'h00);
    @(posedge clk); #1;
    check_data("R7", 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule